// File: doc/BRIEF.md
# Nine-Pin General-Purpose I/O Bank with Alternate Functions

This block controls a bank of nine general-purpose pins through a small register file. Each pin can be set as an input or an output, its output level is programmable, and its level can be read back through a two-flop synchronizer. Any pin can raise an interrupt on a selectable edge. Edges latch into a write-one-to-clear status register, and a per-pin mask combines the status into one active-high interrupt line.

Three pins have an on-chip alternate function. Pins 0 and 1 can be handed to two downstream-port reset signals, which are active low. Those pins are then forced to be outputs and carry the reset value, whatever the direction and output registers hold. Pin 2 can be handed to an active-low expander interrupt. It is then forced to be an input, and its synchronized level goes to an on-chip consumer. The register port is a plain write-strobe plus combinational-read interface. Software, a management-bus slave or a configuration loader can sit behind it. The pad cells lie outside the block.

Top module: `gpio_bank`

## Requirements
- R1: After reset, all outputs are quiet. `pad_oe` is 0 and `pad_out` is 0. The direction, output, alternate-enable, polarity and mask registers read 0, `irq_o` is 0 and `expander_irq_n_o` is 1.
- R2: The direction register is at address 0 (1 = output) and the output register is at address 1. After the clock edge that writes them, `pad_oe` and `pad_out` of every pin without an active alternate function follow them.
- R3: The input register at address 2 returns the pin levels, read-only. A change on `pad_in` becomes visible there after the second rising edge. This holds whatever the direction or alternate settings are.
- R4: The alternate-enable register is at address 3. With bit 0 set, pin 0 is an output that drives `port2_rst_n_i`. With bit 1 set, pin 1 is an output that drives `port4_rst_n_i`. In both cases the direction and output registers are overridden.
- R5: With alternate-enable bit 2 set, pin 2 is never driven, and `expander_irq_n_o` follows the synchronized pin-2 level. With the bit clear, `expander_irq_n_o` is held at 1. Alternate-enable bits 3 to 8 cannot be set and always read 0.
- R6: The polarity register is at address 4 (1 = rising edge, 0 = falling edge). The status register is at address 6. A selected edge on a pin sets its status bit on the third rising edge after the input changes. An edge of the other polarity does not set the bit.
- R7: Writing the status register clears every bit written as 1 and leaves the bits written as 0 unchanged. When a new edge arrives in the same cycle as a clear, the bit stays set.
- R8: The mask register is at address 5 (1 = enabled). `irq_o` is 1 exactly when some status bit is set and its mask bit is also set. Masked pins still latch status.
- R9: Reads from address 7 return 0, and writes to address 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for read and write |
| bus_wdata | input | 9 | Write data, one bit per pin |
| bus_rdata | output | 9 | Combinational read data for `bus_addr` |
| pad_in | input | 9 | Pin levels from the pads |
| pad_out | output | 9 | Output level to the pads |
| pad_oe | output | 9 | Output enable to the pads, 1 = drive |
| port2_rst_n_i | input | 1 | On-chip reset for downstream port 2, active low |
| port4_rst_n_i | input | 1 | On-chip reset for downstream port 4, active low |
| expander_irq_n_o | output | 1 | Expander interrupt to on-chip logic, active low |
| irq_o | output | 1 | Combined interrupt, active high |

## Verification
A wrong configuration register shows on `pad_oe` and `pad_out` at the first negative clock edge after the write. So a stuck or misrouted direction, output or alternate bit is caught with no added delay. Faults in the synchronizer or the edge detector show up as wrong timing: an input register or status bit that changes one edge early or late, or not at all. The bench samples each of these in the exact cycle where the change is due. A status or mask fault reaches `irq_o` in the same cycle as the faulty bit. The clear-versus-set collision is timed so that the write and the edge meet on the same clock edge.

// File: rtl/gpio_pkg.sv
// Package: shared register addresses for the GPIO bank.
// Assumes a 3-bit register address; address 7 is unmapped.
package gpio_pkg;
    localparam int unsigned GPIO_ADDR_W = 3;

    typedef enum logic [GPIO_ADDR_W-1:0] {
        REG_DIR  = 3'd0,
        REG_OUT  = 3'd1,
        REG_IN   = 3'd2,
        REG_ALT  = 3'd3,
        REG_POL  = 3'd4,
        REG_MASK = 3'd5,
        REG_STAT = 3'd6
    } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
// Module: two-flop synchronizer for the pin inputs, plus a warm-up flag.
// The flag rises once the synchronizer and one more delay stage hold
// post-reset data, so edge detection never sees reset values.
// Assumes pad_in may be asynchronous to clk.
module gpio_sync #(
    parameter int unsigned WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             warm
);
    localparam int unsigned WARM_STAGES = 3;

    logic [WIDTH-1:0]       stage1;
    logic [WIDTH-1:0]       stage2;
    logic [WARM_STAGES-1:0] warm_sr;

    // Two-stage capture of the pin levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= din;
            stage2 <= stage1;
        end
    end

    // Warm-up shift register: fills with ones after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) warm_sr <= '0;
        else        warm_sr <= {warm_sr[WARM_STAGES-2:0], 1'b1};
    end

    assign dout = stage2;
    assign warm = warm_sr[WARM_STAGES-1];

    AST_IN_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (dout == $past(din, 2))); // R3
endmodule

// File: rtl/gpio_regs.sv
// Module: configuration register file and read multiplexer.
// Holds direction, output, alternate-enable, polarity and mask. Produces
// the write-one-to-clear vector for the status register. Alternate-enable
// bits outside ALT_MASK are tied to zero.
// Assumes a single-cycle write strobe; reads are combinational.
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int unsigned  NUM_PINS = 9,
    parameter logic [NUM_PINS-1:0] ALT_MASK = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [GPIO_ADDR_W-1:0] addr,
    input  logic [NUM_PINS-1:0]    wdata,
    output logic [NUM_PINS-1:0]    rdata,
    input  logic [NUM_PINS-1:0]    in_level,
    input  logic [NUM_PINS-1:0]    status,
    output logic [NUM_PINS-1:0]    dir_q,
    output logic [NUM_PINS-1:0]    out_q,
    output logic [NUM_PINS-1:0]    alt_q,
    output logic [NUM_PINS-1:0]    pol_q,
    output logic [NUM_PINS-1:0]    mask_q,
    output logic [NUM_PINS-1:0]    clr_vec
);
    logic wr_dir, wr_out, wr_alt, wr_pol, wr_mask;

    // Address decode of the write strobe.
    always_comb begin
        wr_dir  = wr_en && (addr == REG_DIR);
        wr_out  = wr_en && (addr == REG_OUT);
        wr_alt  = wr_en && (addr == REG_ALT);
        wr_pol  = wr_en && (addr == REG_POL);
        wr_mask = wr_en && (addr == REG_MASK);
        clr_vec = (wr_en && (addr == REG_STAT)) ? wdata : '0;
    end

    // Configuration registers, all cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            out_q  <= '0;
            alt_q  <= '0;
            pol_q  <= '0;
            mask_q <= '0;
        end else begin
            if (wr_dir)  dir_q  <= wdata;
            if (wr_out)  out_q  <= wdata;
            if (wr_alt)  alt_q  <= wdata & ALT_MASK;
            if (wr_pol)  pol_q  <= wdata;
            if (wr_mask) mask_q <= wdata;
        end
    end

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        case (addr)
            REG_DIR:  rdata = dir_q;
            REG_OUT:  rdata = out_q;
            REG_IN:   rdata = in_level;
            REG_ALT:  rdata = alt_q;
            REG_POL:  rdata = pol_q;
            REG_MASK: rdata = mask_q;
            REG_STAT: rdata = status;
            default:  rdata = '0;
        endcase
    end

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dir_q == '0 && alt_q == '0 && mask_q == '0)); // R1
    AST_ALT_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_q & ~ALT_MASK) == '0); // R5
endmodule

// File: rtl/gpio_irq.sv
// Module: edge detector, sticky status register and interrupt combiner.
// A per-pin polarity picks the rising or the falling edge. Status bits are
// cleared by writing ones. A new edge wins over a clear in the same cycle.
// Assumes 'level' is already synchronized and 'warm' marks valid history.
module gpio_irq #(
    parameter int unsigned NUM_PINS = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] level,
    input  logic                warm,
    input  logic [NUM_PINS-1:0] pol,
    input  logic [NUM_PINS-1:0] mask,
    input  logic [NUM_PINS-1:0] clr_vec,
    output logic [NUM_PINS-1:0] status,
    output logic                irq
);
    logic [NUM_PINS-1:0] level_prev;
    logic [NUM_PINS-1:0] edge_hit;

    // One-cycle history of the synchronized levels.
    always_ff @(posedge clk) begin
        if (!rst_n) level_prev <= '0;
        else        level_prev <= level;
    end

    // Edge selection by polarity, suppressed until history is valid.
    always_comb begin
        edge_hit = {NUM_PINS{warm}} &
                   ((pol & level & ~level_prev) | (~pol & ~level & level_prev));
    end

    // Sticky status with write-one-to-clear; set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_vec) | edge_hit;
    end

    assign irq = |(status & mask);

    AST_SET_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~$past(status)) != '0) |-> ($past(edge_hit) != '0)); // R6
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 ((($past(status) & ~$past(clr_vec)) & ~status) == '0)); // R7
endmodule

// File: rtl/gpio_pinmux.sv
// Module: per-pin selection between GPIO control and the alternate function.
// Pins flagged in ALT_OUT_MASK are driven from alt_drive when enabled.
// Other enabled alternate pins are forced to inputs.
// Assumes alt_en bits are zero for pins with no alternate function.
module gpio_pinmux #(
    parameter int unsigned NUM_PINS = 9,
    parameter logic [NUM_PINS-1:0] ALT_OUT_MASK = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] dir,
    input  logic [NUM_PINS-1:0] out_val,
    input  logic [NUM_PINS-1:0] alt_en,
    input  logic [NUM_PINS-1:0] alt_drive,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        // Alternate function overrides direction and value for this pin.
        always_comb begin
            if (alt_en[i]) begin
                pad_oe[i]  = ALT_OUT_MASK[i];
                pad_out[i] = ALT_OUT_MASK[i] ? alt_drive[i] : out_val[i];
            end else begin
                pad_oe[i]  = dir[i];
                pad_out[i] = out_val[i];
            end
        end
    end

    AST_ALT_IN_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((alt_en & ~ALT_OUT_MASK & pad_oe) == '0)); // R5
    AST_ALT_OUT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((alt_en & ALT_OUT_MASK & ~pad_oe) == '0)); // R4
endmodule

// File: rtl/gpio_bank.sv
// Module: top of the GPIO bank. Wires the synchronizer, register file,
// interrupt logic and pin multiplexer together. It also maps the two
// port-reset outputs and the expander interrupt input onto their pins.
// Assumes NUM_PINS covers the three alternate pin indices.
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int unsigned NUM_PINS  = 9,
    parameter int unsigned RST_A_PIN = 0,
    parameter int unsigned RST_B_PIN = 1,
    parameter int unsigned EXP_PIN   = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr_en,
    input  logic [GPIO_ADDR_W-1:0] bus_addr,
    input  logic [NUM_PINS-1:0]    bus_wdata,
    output logic [NUM_PINS-1:0]    bus_rdata,
    input  logic [NUM_PINS-1:0]    pad_in,
    output logic [NUM_PINS-1:0]    pad_out,
    output logic [NUM_PINS-1:0]    pad_oe,
    input  logic                   port2_rst_n_i,
    input  logic                   port4_rst_n_i,
    output logic                   expander_irq_n_o,
    output logic                   irq_o
);
    localparam logic [NUM_PINS-1:0] OUT_ALTS = NUM_PINS'((1 << RST_A_PIN) | (1 << RST_B_PIN));
    localparam logic [NUM_PINS-1:0] IN_ALTS  = NUM_PINS'(1 << EXP_PIN);
    localparam logic [NUM_PINS-1:0] ALL_ALTS = OUT_ALTS | IN_ALTS;

    logic [NUM_PINS-1:0] in_level, status, clr_vec;
    logic [NUM_PINS-1:0] dir_q, out_q, alt_q, pol_q, mask_q;
    logic [NUM_PINS-1:0] alt_drive;
    logic                warm;

    // Place the on-chip reset signals on their pin positions.
    always_comb begin
        alt_drive            = '0;
        alt_drive[RST_A_PIN] = port2_rst_n_i;
        alt_drive[RST_B_PIN] = port4_rst_n_i;
    end

    gpio_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(in_level), .warm(warm)
    );

    gpio_regs #(.NUM_PINS(NUM_PINS), .ALT_MASK(ALL_ALTS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .in_level(in_level),
        .status(status), .dir_q(dir_q), .out_q(out_q), .alt_q(alt_q),
        .pol_q(pol_q), .mask_q(mask_q), .clr_vec(clr_vec)
    );

    gpio_irq #(.NUM_PINS(NUM_PINS)) u_irq (
        .clk(clk), .rst_n(rst_n), .level(in_level), .warm(warm), .pol(pol_q),
        .mask(mask_q), .clr_vec(clr_vec), .status(status), .irq(irq_o)
    );

    gpio_pinmux #(.NUM_PINS(NUM_PINS), .ALT_OUT_MASK(OUT_ALTS)) u_pinmux (
        .clk(clk), .rst_n(rst_n), .dir(dir_q), .out_val(out_q), .alt_en(alt_q),
        .alt_drive(alt_drive), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // Expander interrupt: pin level when selected, otherwise idle high.
    assign expander_irq_n_o = alt_q[EXP_PIN] ? in_level[EXP_PIN] : 1'b1;

    AST_EXP_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !alt_q[EXP_PIN] |-> expander_irq_n_o); // R5
endmodule

// File: tb/test_gpio_bank.sv
// Directed bench for gpio_bank: one task per scenario, each checking itself.
module test_gpio_bank;
    localparam int N = 9;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr_en = 1'b0;
    logic [2:0]   bus_addr = 3'd0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] pad_out, pad_oe;
    logic         port2_rst_n_i = 1'b0;
    logic         port4_rst_n_i = 1'b0;
    logic         expander_irq_n_o, irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    gpio_bank i_gpio_bank (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .port2_rst_n_i(port2_rst_n_i),
        .port4_rst_n_i(port4_rst_n_i), .expander_irq_n_o(expander_irq_n_o),
        .irq_o(irq_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_neg(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [N-1:0] v;
        check(pad_oe == '0, "R1 oe", pad_oe, 0);
        check(pad_out == '0, "R1 out", pad_out, 0);
        check(irq_o == 1'b0, "R1 irq", irq_o, 0);
        check(expander_irq_n_o == 1'b1, "R1 exp", expander_irq_n_o, 1);
        for (int a = 0; a < 6; a++) begin
            if (a == 2) continue;
            rd(3'(a), v);
            check(v == '0, "R1 regs", v, 0);
        end
    endtask

    task automatic t_dir_out();
        logic [N-1:0] v;
        wr(3'd0, 9'h1A5);
        wr(3'd1, 9'h0F0);
        check(pad_oe == 9'h1A5, "R2 oe", pad_oe, 9'h1A5);
        check(pad_out == 9'h0F0, "R2 out", pad_out, 9'h0F0);
        rd(3'd1, v);
        check(v == 9'h0F0, "R2 readback", v, 9'h0F0);
    endtask

    task automatic t_input_sync();
        logic [N-1:0] v;
        @(negedge clk); pad_in = 9'h155;
        wait_neg(1);
        rd(3'd2, v);
        check(v == 9'h000, "R3 one edge", v, 0);
        wait_neg(1);
        rd(3'd2, v);
        check(v == 9'h155, "R3 two edges", v, 9'h155);
        @(negedge clk); pad_in = 9'h0AA;
        wait_neg(2);
        rd(3'd2, v);
        check(v == 9'h0AA, "R3 second pattern", v, 9'h0AA);
    endtask

    task automatic t_alt_outputs();
        logic [N-1:0] v;
        port2_rst_n_i = 1'b1; port4_rst_n_i = 1'b0;
        wr(3'd3, 9'h1FF);
        rd(3'd3, v);
        check(v == 9'h007, "R5 alt reserved", v, 9'h007);
        check(pad_oe[1:0] == 2'b11, "R4 forced oe", pad_oe[1:0], 3);
        check(pad_out[1:0] == 2'b01, "R4 drive", pad_out[1:0], 1);
        check(pad_oe[8:3] == 6'b110100, "R4 others keep dir", pad_oe[8:3], 6'h34);
        port4_rst_n_i = 1'b1; #1;
        check(pad_out[1] == 1'b1, "R4 follow port4", pad_out[1], 1);
        check(pad_oe[2] == 1'b0, "R5 pin2 input", pad_oe[2], 0);
        wr(3'd3, 9'h000);
        check(pad_oe == 9'h1A5, "R4 release", pad_oe, 9'h1A5);
        check(pad_out[1:0] == 2'b00, "R4 release out", pad_out[1:0], 0);
    endtask

    task automatic t_alt_input();
        wr(3'd3, 9'h004);
        @(negedge clk); pad_in[2] = 1'b1;
        wait_neg(2);
        check(expander_irq_n_o == 1'b1, "R5 exp high", expander_irq_n_o, 1);
        @(negedge clk); pad_in[2] = 1'b0;
        wait_neg(2);
        check(expander_irq_n_o == 1'b0, "R5 exp low", expander_irq_n_o, 0);
        wr(3'd3, 9'h000);
        check(expander_irq_n_o == 1'b1, "R5 exp idle", expander_irq_n_o, 1);
    endtask

    task automatic t_edges();
        logic [N-1:0] v;
        @(negedge clk); pad_in = '0;
        wait_neg(3);
        wr(3'd6, 9'h1FF);
        wr(3'd4, 9'h00F);
        @(negedge clk); pad_in = 9'h1FF;
        wait_neg(2);
        rd(3'd6, v);
        check(v == 9'h000, "R6 not yet", v, 0);
        wait_neg(1);
        rd(3'd6, v);
        check(v == 9'h00F, "R6 rising only", v, 9'h00F);
        check(irq_o == 1'b0, "R8 masked", irq_o, 0);
        @(negedge clk); pad_in = 9'h000;
        wait_neg(3);
        rd(3'd6, v);
        check(v == 9'h1FF, "R6 falling", v, 9'h1FF);
    endtask

    task automatic t_w1c_mask();
        logic [N-1:0] v;
        wr(3'd6, 9'h003);
        rd(3'd6, v);
        check(v == 9'h1FC, "R7 clear ones", v, 9'h1FC);
        wr(3'd6, 9'h000);
        rd(3'd6, v);
        check(v == 9'h1FC, "R7 zero no effect", v, 9'h1FC);
        wr(3'd5, 9'h004);
        check(irq_o == 1'b1, "R8 enabled", irq_o, 1);
        wr(3'd6, 9'h004);
        check(irq_o == 1'b0, "R8 cleared", irq_o, 0);
        wr(3'd6, 9'h020);
        @(negedge clk); pad_in[5] = 1'b1;
        wait_neg(3);
        @(negedge clk); pad_in[5] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = 3'd6; bus_wdata = 9'h020;
        @(negedge clk);
        bus_wr_en = 1'b0;
        rd(3'd6, v);
        check(v[5] == 1'b1, "R7 set wins", v[5], 1);
    endtask

    task automatic t_unmapped();
        logic [N-1:0] v;
        wr(3'd7, 9'h1FF);
        rd(3'd7, v);
        check(v == '0, "R9 read zero", v, 0);
        rd(3'd0, v);
        check(v == 9'h1A5, "R9 dir unchanged", v, 9'h1A5);
        rd(3'd5, v);
        check(v == 9'h004, "R9 mask unchanged", v, 9'h004);
    endtask

    initial begin
        wait_neg(3);
        t_reset();
        rst_n = 1'b1;
        wait_neg(4);
        t_reset();
        t_dir_out();
        t_input_sync();
        t_alt_outputs();
        t_alt_input();
        t_edges();
        t_w1c_mask();
        t_unmapped();
        done = 1;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule